// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches sixteen external interrupt lines. Each line takes its input from one of up to seven general-purpose pin ports. A per-line selector picks the port. The picked pin passes through a two-flop synchronizer, and the block then compares it with its value from the previous cycle to find rising and falling edges. Each line has its own rising and falling trigger enables. A qualifying edge latches a pending flag for that line. The flag drives the line's interrupt output when the line is unmasked. A second mask gates a one-cycle event pulse that does not depend on the pending flag.

Software reaches the block through a plain 32-bit register bus. Writes take effect at the clock edge where `bus_wr` is high, and reads are combinational from `bus_addr`. Software can force a line pending through a trigger register. It clears pending flags by writing ones. Port selection is held in four packed select registers, in an address region separate from the line control registers. The bus has no handshake: every access completes in one cycle.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every readable register reads 0 and `irq_o` and `evt_o` are all low. All select fields are therefore 0, which is port A.
- R2: The line control registers are decoded when `bus_addr[5]`=0, using word offsets: 0x00 interrupt mask, 0x04 event mask, 0x08 rising enable, 0x0C falling enable, 0x10 software trigger, 0x14 pending. Line n is bit n, and bits 31:16 read 0.
- R3: The select registers are decoded when `bus_addr[5]`=1, at offsets 0x08, 0x0C, 0x10 and 0x14 (addresses 0x28 to 0x34). Line n uses select register n/4, bits [4*(n%4)+3 : 4*(n%4)]. Code k from 0 to 6 picks `gpio_in[16*k+n]`. Codes 7 to 15 feed a constant 0.
- R4: A pin change driven before clock edge 1 sets the pending bit at edge 3, counting two synchronizer flops and the previous-value flop.
- R5: A rising edge sets pending only when the line's rising enable is 1. A falling edge sets pending only when the falling enable is 1. With both enables set, either edge sets pending.
- R6: `irq_o[n]` is high exactly when line n is pending and its interrupt mask bit is 1.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R8: If a qualifying edge and a write-1 clear of the same pending bit occur in the same cycle, the bit stays pending.
- R9: Writing 1 to a software trigger bit sets that bit and the line's pending bit at the same edge. The trigger bit reads back 1 until a write-1 clear of the pending bit clears both.
- R10: `evt_o[n]` pulses high for exactly one cycle, starting at the edge where pending is set by a qualifying edge or a software trigger, and only when event mask bit n is 1. The pulse occurs even when the line is already pending.

Verification in short: the pending-clear race, the select field packing, and event pulses while a line is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpio_in | input | 112 | Pin ports; port k pin n at bit 16*k+n |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address; bit 5 selects the select-register region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_o | output | 16 | Per-line interrupt request |
| evt_o | output | 16 | Per-line single-cycle event pulse |

## Verification
The hardest case to reach from the ports is the race in R8. An edge must reach the detector in exactly the cycle in which a write-1 clear lands. The bench makes the line pending first. It then drives the opposite edge on the pin and issues the clear two cycles later, so the write meets the edge at edge 3. Select packing is checked by driving the same pin number on a wrong port and on the right port. Event pulses are checked while the line is already pending.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned LINE_W = 3;
  typedef enum logic [LINE_W-1:0] {
    RG_IMASK  = 3'd0,
    RG_EMASK  = 3'd1,
    RG_RISE   = 3'd2,
    RG_FALL   = 3'd3,
    RG_SWTRIG = 3'd4,
    RG_PEND   = 3'd5
  } lreg_e;
  localparam logic [LINE_W-1:0] SEL_FIRST = 3'd2;
endpackage

// File: rtl/eirq_src_mux.sv
module eirq_src_mux #(
  parameter int unsigned NUM_PORTS = 7,
  parameter int unsigned SEL_W     = 4
) (
  input  logic [NUM_PORTS-1:0] pins,
  input  logic [SEL_W-1:0]     sel,
  output logic                 pin
);
  always_comb begin
    pin = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel == SEL_W'(p)) pin = pins[p];
    end
  end
endmodule

// File: rtl/eirq_edge.sv
module eirq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_en,
  input  logic fall_en,
  output logic hit
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    hit = (rise_en & sync_q & ~prev_q) | (fall_en & ~sync_q & prev_q);
  end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned PER_SEL   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_LINES-1:0]       hit,
  output logic [NUM_LINES-1:0]       imask,
  output logic [NUM_LINES-1:0]       emask,
  output logic [NUM_LINES-1:0]       rise_en,
  output logic [NUM_LINES-1:0]       fall_en,
  output logic [NUM_LINES-1:0]       swtrig,
  output logic [NUM_LINES-1:0]       pend,
  output logic [NUM_LINES-1:0]       set_v,
  output logic [NUM_LINES-1:0]       evt,
  output logic [NUM_LINES*SEL_W-1:0] sel_flat
);
  localparam int unsigned SEL_REGS = NUM_LINES / PER_SEL;
  localparam int unsigned FIELD_W  = PER_SEL * SEL_W;

  logic [SEL_REGS-1:0][FIELD_W-1:0] sel_q;
  logic [LINE_W-1:0]    lsel;
  logic                 sel_rgn;
  logic                 wr_line;
  logic [LINE_W-1:0]    sidx;
  logic                 sidx_ok;
  logic [NUM_LINES-1:0] wbits;
  logic [NUM_LINES-1:0] sw_set;
  logic [NUM_LINES-1:0] pend_clr;

  always_comb begin
    lsel     = bus_addr[LINE_W+1:2];
    sel_rgn  = bus_addr[ADDR_W-1];
    wr_line  = bus_wr & ~sel_rgn;
    sidx     = lsel - SEL_FIRST;
    sidx_ok  = (lsel >= SEL_FIRST) && (int'(sidx) < SEL_REGS);
    wbits    = bus_wdata[NUM_LINES-1:0];
    sw_set   = (wr_line && lsel == RG_SWTRIG) ? wbits : '0;
    pend_clr = (wr_line && lsel == RG_PEND)   ? wbits : '0;
    set_v    = hit | sw_set;
    sel_flat = sel_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imask   <= '0;
      emask   <= '0;
      rise_en <= '0;
      fall_en <= '0;
      swtrig  <= '0;
      pend    <= '0;
      evt     <= '0;
      sel_q   <= '0;
    end else begin
      if (wr_line && lsel == RG_IMASK) imask   <= wbits;
      if (wr_line && lsel == RG_EMASK) emask   <= wbits;
      if (wr_line && lsel == RG_RISE)  rise_en <= wbits;
      if (wr_line && lsel == RG_FALL)  fall_en <= wbits;
      swtrig <= (swtrig | sw_set) & ~pend_clr;
      pend   <= (pend & ~pend_clr) | set_v;
      evt    <= set_v & emask;
      if (bus_wr && sel_rgn && sidx_ok)
        sel_q[sidx] <= bus_wdata[FIELD_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!sel_rgn) begin
      case (lsel)
        RG_IMASK:  bus_rdata = DATA_W'(imask);
        RG_EMASK:  bus_rdata = DATA_W'(emask);
        RG_RISE:   bus_rdata = DATA_W'(rise_en);
        RG_FALL:   bus_rdata = DATA_W'(fall_en);
        RG_SWTRIG: bus_rdata = DATA_W'(swtrig);
        RG_PEND:   bus_rdata = DATA_W'(pend);
        default:   bus_rdata = '0;
      endcase
    end else if (sidx_ok) begin
      bus_rdata = DATA_W'(sel_q[sidx]);
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned NUM_PORTS = 7,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned PORT_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0]   gpio_in,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic [NUM_LINES-1:0]          irq_o,
  output logic [NUM_LINES-1:0]          evt_o
);
  localparam int unsigned PER_SEL = 4;

  logic [NUM_LINES-1:0]       imask, emask, rise_en, fall_en;
  logic [NUM_LINES-1:0]       swtrig, pend, set_v, hit, evt;
  logic [NUM_LINES*SEL_W-1:0] sel_flat;

  eirq_regs #(
    .NUM_LINES(NUM_LINES), .SEL_W(SEL_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .PER_SEL(PER_SEL)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hit(hit),
    .imask(imask), .emask(emask), .rise_en(rise_en), .fall_en(fall_en),
    .swtrig(swtrig), .pend(pend), .set_v(set_v), .evt(evt),
    .sel_flat(sel_flat)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [NUM_PORTS-1:0] pins;
    logic                 src;
    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
      assign pins[k] = gpio_in[k*PORT_W + n];
    end
    eirq_src_mux #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) i_mux (
      .pins(pins), .sel(sel_flat[n*SEL_W +: SEL_W]), .pin(src)
    );
    eirq_edge i_edge (
      .clk(clk), .rst_n(rst_n), .din(src),
      .rise_en(rise_en[n]), .fall_en(fall_en[n]), .hit(hit[n])
    );
  end

  assign irq_o = pend & imask;
  assign evt_o = evt;
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk #(
  parameter int unsigned NUM_LINES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_o,
  input logic [NUM_LINES-1:0] evt_o,
  input logic [NUM_LINES-1:0] imask,
  input logic [NUM_LINES-1:0] emask,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] swtrig,
  input logic [NUM_LINES-1:0] set_v
);
  a_r6_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~pend) == '0);

  a_r6_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~imask) == '0);

  a_r10_evt_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_o) |-> ((evt_o & ~$past(emask)) == '0));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((pend & $past(set_v)) == $past(set_v)));

  a_r9_swtrig_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (swtrig & ~pend) == '0);

  a_r4_pend_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) & ~$past(set_v)) == '0);
endmodule

bind ext_irq_ctrl eirq_chk #(.NUM_LINES(NUM_LINES)) i_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .evt_o(evt_o), .imask(imask),
  .emask(emask), .pend(pend), .swtrig(swtrig), .set_v(set_v)
);

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;
  localparam int unsigned L = 16;
  localparam logic [5:0] A_IMASK = 6'h00, A_EMASK = 6'h04, A_RISE = 6'h08,
                         A_FALL = 6'h0C, A_SWT = 6'h10, A_PEND = 6'h14,
                         A_SEL0 = 6'h28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [111:0] gpio_in = '0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_o, evt_o;
  int total = 0;
  int bad = 0;

  ext_irq_ctrl i_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .evt_o(evt_o)
  );

  always #10 clk = ~clk;

  // fields: line[11:8] code[7:4] rise[3] fall[2] rising_pulse[1] expect[0]
  localparam int NV = 9;
  localparam logic [11:0] VEC [NV] = '{
    {4'd0,  4'd0, 1'b1, 1'b0, 1'b1, 1'b1},
    {4'd1,  4'd1, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'd5,  4'd2, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd6,  4'd3, 1'b1, 1'b1, 1'b1, 1'b1},
    {4'd9,  4'd4, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd10, 4'd5, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd15, 4'd6, 1'b1, 1'b0, 1'b1, 1'b1},
    {4'd3,  4'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd12, 4'd1, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [5:0] sel_addr(input int line);
    return A_SEL0 + 6'(4 * (line / 4));
  endfunction

  task automatic set_code(input int line, input logic [3:0] code);
    logic [31:0] v;
    rd(sel_addr(line), v);
    v[4*(line%4) +: 4] = code;
    wr(sel_addr(line), v);
  endtask

  initial begin
    #4_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    cyc(4);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(6'(4 * a), v);
      chk("R1 line reg after reset", v, 32'h0);
    end
    rd(A_SEL0 + 6'd12, v);
    chk("R1 select reg after reset", v, 32'h0);
    chk("R1 irq_o after reset", {16'h0, irq_o}, 32'h0);
    chk("R1 evt_o after reset", {16'h0, evt_o}, 32'h0);

    // R2 line register map readback
    wr(A_IMASK, 32'hFFFF_A5A5); rd(A_IMASK, v); chk("R2 imask readback", v, 32'h0000_A5A5);
    wr(A_RISE, 32'h0000_1234);  rd(A_RISE, v);  chk("R2 rise readback", v, 32'h0000_1234);
    rd(A_FALL, v); chk("R2 fall untouched", v, 32'h0);
    wr(A_IMASK, 32'h0); wr(A_RISE, 32'h0);

    // R3 select register readback
    wr(A_SEL0 + 6'd4, 32'hFFFF_6543); rd(A_SEL0 + 6'd4, v);
    chk("R3 select reg1 readback", v, 32'h0000_6543);
    wr(A_SEL0 + 6'd4, 32'h0);

    // table: R4 R5 R10 with event mask on
    wr(A_EMASK, 32'h0000_FFFF);
    for (int i = 0; i < NV; i++) begin
      int line; int code; int bitp; logic up; logic ex;
      line = int'(VEC[i][11:8]); code = int'(VEC[i][7:4]);
      up = VEC[i][1]; ex = VEC[i][0];
      bitp = 16 * code + line;
      set_code(line, 4'(code));
      gpio_in[bitp] = ~up;
      cyc(4);
      wr(A_RISE, 32'(VEC[i][3]) << line);
      wr(A_FALL, 32'(VEC[i][2]) << line);
      wr(A_PEND, 32'h0000_FFFF);
      gpio_in[bitp] = up;
      cyc(3);
      chk($sformatf("R10 table %0d evt", i), 32'(evt_o[line]), 32'(ex));
      rd(A_PEND, v);
      chk($sformatf("R5 R4 table %0d pending", i), 32'(v[line]), 32'(ex));
      cyc(1);
      chk($sformatf("R10 table %0d evt one cycle", i), 32'(evt_o[line]), 32'h0);
      wr(A_RISE, 32'h0); wr(A_FALL, 32'h0);
      gpio_in[bitp] = 1'b0;
      cyc(4);
      wr(A_PEND, 32'h0000_FFFF);
      set_code(line, 4'd0);
    end

    // R4 exact latency: not pending after two edges
    wr(A_RISE, 32'h0000_0010);
    gpio_in[4] = 1'b1;
    cyc(2); rd(A_PEND, v);
    chk("R4 not pending at edge 2", v, 32'h0);
    cyc(1); rd(A_PEND, v);
    chk("R4 pending at edge 3", v, 32'h0000_0010);

    // R6 irq gated by mask
    chk("R6 irq low while masked", {16'h0, irq_o}, 32'h0);
    wr(A_IMASK, 32'h0000_0010);
    chk("R6 irq high when unmasked", {16'h0, irq_o}, 32'h0000_0010);

    // R7 write 0 no effect, write 1 clears
    wr(A_PEND, 32'h0); rd(A_PEND, v);
    chk("R7 write 0 keeps pending", v, 32'h0000_0010);
    wr(A_PEND, 32'h0000_0010); rd(A_PEND, v);
    chk("R7 write 1 clears", v, 32'h0);
    chk("R6 irq drops after clear", {16'h0, irq_o}, 32'h0);

    // R10 evt while already pending; R8 set wins over clear
    wr(A_FALL, 32'h0000_0010);
    gpio_in[4] = 1'b0;
    cyc(3);
    chk("R10 evt on falling", {16'h0, evt_o}, 32'h0000_0010);
    gpio_in[4] = 1'b1;
    cyc(3);
    chk("R10 evt while already pending", {16'h0, evt_o}, 32'h0000_0010);
    gpio_in[4] = 1'b0;
    cyc(2);
    wr(A_PEND, 32'h0000_0010);
    rd(A_PEND, v);
    chk("R8 edge beats clear", v, 32'h0000_0010);
    wr(A_PEND, 32'h0000_0010); rd(A_PEND, v);
    chk("R8 later clear works", v, 32'h0);
    wr(A_RISE, 32'h0); wr(A_FALL, 32'h0); wr(A_IMASK, 32'h0);

    // R10 masked event: pending sets, no pulse
    wr(A_EMASK, 32'h0);
    wr(A_RISE, 32'h0000_0001);
    gpio_in[0] = 1'b1;
    cyc(3);
    chk("R10 no evt when masked", {16'h0, evt_o}, 32'h0);
    rd(A_PEND, v);
    chk("R10 pending despite event mask", v, 32'h0000_0001);
    wr(A_RISE, 32'h0); gpio_in[0] = 1'b0; cyc(4);
    wr(A_PEND, 32'h0000_FFFF);

    // R9 software trigger
    wr(A_EMASK, 32'h0000_0080);
    wr(A_SWT, 32'h0000_0080);
    chk("R9 swtrig evt pulse", {16'h0, evt_o}, 32'h0000_0080);
    rd(A_PEND, v); chk("R9 swtrig sets pending", v, 32'h0000_0080);
    rd(A_SWT, v);  chk("R9 swtrig bit reads 1", v, 32'h0000_0080);
    cyc(1);
    chk("R9 R10 swtrig evt one cycle", {16'h0, evt_o}, 32'h0);
    wr(A_PEND, 32'h0000_0080);
    rd(A_SWT, v);  chk("R9 swtrig cleared with pending", v, 32'h0);
    rd(A_PEND, v); chk("R9 pending cleared", v, 32'h0);

    // R3 code 7 reads constant 0; packing line 13 to port C
    wr(A_EMASK, 32'h0);
    set_code(2, 4'd7);
    wr(A_RISE, 32'h0000_2004);
    for (int k = 0; k < 7; k++) gpio_in[16*k + 2] = 1'b1;
    cyc(4); rd(A_PEND, v);
    chk("R3 code 7 gives no source", v, 32'h0);
    set_code(13, 4'd2);
    gpio_in[13] = 1'b1;
    cyc(4); rd(A_PEND, v);
    chk("R3 wrong port ignored for line 13", v, 32'h0);
    gpio_in[2*16 + 13] = 1'b1;
    cyc(4); rd(A_PEND, v);
    chk("R3 line 13 follows port C", v, 32'h0000_2000);
    rd(A_SEL0 + 6'd12, v);
    chk("R3 line 13 field position", v, 32'h0000_0020);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule